// File: doc/BRIEF.md
# Lock-Aware Instruction Cache Block Invalidate Unit

This block keeps the tag, valid and lock state of a small two-way set-associative instruction cache and carries out single-block invalidate requests on it. A request arrives with a physical address that has already been translated, together with the status the translation produced: whether relocation is on, whether a translation was found, and whether the page forbids loads or stores. Attribute bits for the page and the privilege level of the requester come along as well, and the unit ignores them.

A request that hits a valid, unlocked line invalidates it. A miss, or a hit on a locked line, leaves the array alone and still completes. A request is treated as a store for checking: a missing translation under relocation raises a translation-miss exception, and a store-permission violation raises a translation-error exception. In both cases the array is not touched. Exactly one of done, translation-miss or translation-error pulses in the cycle after a request is accepted. Requests are never forwarded anywhere, and no outside invalidate source exists.

A fill port installs a line and may lock it. An unlock port clears a lock. A combinational lookup port shows whether an address is present and locked. When a set is full, the fill replaces an unlocked way, or is refused when both ways are locked.

Top module: `icache_inval_unit`

## Requirements
- R1: An accepted request with no exception that hits a valid line with a clear lock bit clears that line's valid bit at the accepting edge. A lookup of the same address then reports a miss.
- R2: An accepted request that misses, or hits a locked line, leaves every tag, valid and lock bit unchanged and still signals done.
- R3: One cycle after an accepted request, exactly one of `done`, `xlate_miss_exc` or `xlate_err_exc` is high, for that single cycle. No response appears without an accepted request.
- R4: `req_attr` (3 page attribute bits) and `req_user` change neither the response nor the array.
- R5: When `req_relocate`=1 and `req_xlate_hit`=0, the response is `xlate_miss_exc` and the array is unchanged. When `req_relocate`=0, a missing translation is not a fault.
- R6: When no translation miss applies and `req_wr_viol`=1, the response is `xlate_err_exc` and the array is unchanged. `req_rd_viol` alone causes no fault.
- R7: `req_ready` is low in any cycle where `fill_valid` or `unlock_valid` is high, and high otherwise.
- R8: Addresses split as offset [3:0], set index [9:4] and tag [31:10]. A fill installs its line as valid with the lock bit taken from `fill_lock`. A fill of a line that is already present rewrites its lock bit in place.
- R9: A fill goes to the first invalid way of the set (way 0 before way 1). In a full set it replaces the only unlocked way. When both ways are unlocked, it replaces the way that a per-set replacement bit names. That bit is 0 after reset and, after every install, names the other way.
- R10: A fill to a set whose two ways are both valid and locked, with no tag match, changes nothing and raises `fill_reject` for exactly the next cycle.
- R11: An unlock that hits clears that line's lock bit and keeps it valid. An unlock that misses has no effect.
- R12: A synchronous reset clears every valid bit, lock bit and replacement bit, and all response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Invalidate request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 32 | Translated physical address of the block |
| req_relocate | input | 1 | Data address relocation enabled |
| req_xlate_hit | input | 1 | A translation was found for the address |
| req_rd_viol | input | 1 | Page forbids loads |
| req_wr_viol | input | 1 | Page forbids stores |
| req_attr | input | 3 | Page attributes (write policy, inhibit, guarded), ignored |
| req_user | input | 1 | Requester runs in user mode, ignored |
| done | output | 1 | Request completed normally |
| xlate_miss_exc | output | 1 | Translation-miss exception |
| xlate_err_exc | output | 1 | Translation-error (protection) exception |
| fill_valid | input | 1 | Install a line |
| fill_addr | input | 32 | Address of the line to install |
| fill_lock | input | 1 | Lock the installed line |
| fill_reject | output | 1 | Previous fill refused, both ways locked |
| unlock_valid | input | 1 | Clear a line's lock |
| unlock_addr | input | 32 | Address of the line to unlock |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | Lookup address is present |
| lk_locked | output | 1 | Lookup address is present and locked |

## Verification
The assertions assume that at most one fill and one unlock arrive per cycle, and that the translation status inputs are stable whenever `req_valid` is high. They also assume the array never holds the same tag twice in one set. The bench keeps to these limits. It drives each operation for exactly one cycle after a falling edge, and it raises fill and request together only in the test of `req_ready` blocking. It only installs lines through the fill port, which merges a repeated tag into its existing way, so duplicate tags cannot build up.

// File: rtl/icinv_pkg.sv
package icinv_pkg;

  typedef enum logic [1:0] {
    RESP_NONE = 2'd0,
    RESP_DONE = 2'd1,
    RESP_MISS = 2'd2,
    RESP_ERR  = 2'd3
  } resp_e;

  // Tag comparison result for one set
  typedef struct packed {
    logic hit;
    logic way;
    logic locked;
  } match_t;

  // Way chosen for a fill
  typedef struct packed {
    logic ok;
    logic way;
  } victim_t;

  // Outcome of an invalidate request, checked as a store access
  function automatic resp_e classify_req(input logic relocate,
                                         input logic xlate_hit,
                                         input logic wr_viol);
    if (relocate && !xlate_hit) return RESP_MISS;
    if (wr_viol)                return RESP_ERR;
    return RESP_DONE;
  endfunction

  // Fill placement: existing line, then a free way, then an unlocked way
  function automatic victim_t pick_victim(input match_t     hm,
                                          input logic [1:0] val,
                                          input logic [1:0] lck,
                                          input logic       repl);
    victim_t v;
    v.ok  = 1'b1;
    v.way = 1'b0;
    if (hm.hit)                 v.way = hm.way;
    else if (!val[0])           v.way = 1'b0;
    else if (!val[1])           v.way = 1'b1;
    else if (!lck[0] && !lck[1]) v.way = repl;
    else if (!lck[0])           v.way = 1'b0;
    else if (!lck[1])           v.way = 1'b1;
    else                        v.ok  = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/icinv_tag_array.sv
module icinv_tag_array #(
  parameter int SETS  = 64,
  parameter int TAG_W = 22,
  parameter int NRP   = 4,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NRP-1:0][IDX_W-1:0]         rd_idx,
  output logic [NRP-1:0][1:0][TAG_W-1:0]    rd_tag,
  output logic [NRP-1:0][1:0]               rd_val,
  output logic [NRP-1:0][1:0]               rd_lck,
  output logic [NRP-1:0]                    rd_repl,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic                              wr_way,
  input  logic                              wr_tag_en,
  input  logic [TAG_W-1:0]                  wr_tag,
  input  logic                              wr_val,
  input  logic                              wr_lck,
  input  logic                              repl_en,
  input  logic                              repl_val
);

  logic [SETS-1:0] repl_q;

  always_ff @(posedge clk) begin
    if (rst)                  repl_q <= '0;
    else if (wr_en && repl_en) repl_q[wr_idx] <= repl_val;
  end

  for (genvar p = 0; p < NRP; p++) begin : g_repl_rd
    assign rd_repl[p] = repl_q[rd_idx[p]];
  end

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  val_q;
    logic [SETS-1:0]  lck_q;
    logic             sel;

    assign sel = wr_en && (wr_way == 1'(w));

    always_ff @(posedge clk) begin
      if (rst) begin
        val_q <= '0;
        lck_q <= '0;
      end else if (sel) begin
        val_q[wr_idx] <= wr_val;
        lck_q[wr_idx] <= wr_lck;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && wr_tag_en) tag_mem[wr_idx] <= wr_tag;
    end

    for (genvar p = 0; p < NRP; p++) begin : g_rd
      assign rd_tag[p][w] = tag_mem[rd_idx[p]];
      assign rd_val[p][w] = val_q[rd_idx[p]];
      assign rd_lck[p][w] = lck_q[rd_idx[p]];
    end
  end

endmodule

// File: rtl/icinv_way_match.sv
module icinv_way_match
  import icinv_pkg::*;
#(
  parameter int TAG_W = 22
) (
  input  logic [TAG_W-1:0]      key,
  input  logic [1:0][TAG_W-1:0] tags,
  input  logic [1:0]            val,
  input  logic [1:0]            lck,
  output match_t                m
);

  logic [1:0] way_hit;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign way_hit[w] = val[w] && (tags[w] == key);
  end

  always_comb begin
    m.hit    = |way_hit;
    m.way    = way_hit[1] && !way_hit[0];
    m.locked = m.way ? lck[1] : lck[0];
  end

endmodule

// File: rtl/icinv_req_ctrl.sv
module icinv_req_ctrl
  import icinv_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_relocate,
  input  logic             req_xlate_hit,
  input  logic             req_wr_viol,
  input  logic [IDX_W-1:0] req_idx,
  input  match_t           req_m,
  input  logic             fill_valid,
  input  logic             fill_lock,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  match_t           fill_m,
  input  logic [1:0]       fill_val,
  input  logic [1:0]       fill_lck,
  input  logic             fill_repl,
  input  logic             unlock_valid,
  input  logic [IDX_W-1:0] unlock_idx,
  input  match_t           unlock_m,
  output logic             done,
  output logic             xlate_miss_exc,
  output logic             xlate_err_exc,
  output logic             fill_reject,
  output logic             req_acc,
  output logic             inv_kill,
  output logic             fill_install,
  output logic             fill_refuse,
  output logic             unlock_clear,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_way,
  output logic             wr_tag_en,
  output logic [TAG_W-1:0] wr_tag,
  output logic             wr_val,
  output logic             wr_lck,
  output logic             repl_en,
  output logic             repl_val
);

  resp_e   resp_now;
  resp_e   resp_q;
  victim_t vic;
  logic    reject_q;

  assign req_ready = !fill_valid && !unlock_valid;
  assign req_acc   = req_valid && req_ready;
  assign resp_now  = classify_req(req_relocate, req_xlate_hit, req_wr_viol);
  assign inv_kill  = req_acc && (resp_now == RESP_DONE) && req_m.hit && !req_m.locked;

  assign vic          = pick_victim(fill_m, fill_val, fill_lck, fill_repl);
  assign fill_install = fill_valid && vic.ok;
  assign fill_refuse  = fill_valid && !vic.ok;
  assign unlock_clear = !fill_valid && unlock_valid && unlock_m.hit;

  // One array write per cycle; fill over unlock, requests only when both idle
  always_comb begin
    wr_en     = 1'b0;
    wr_idx    = req_idx;
    wr_way    = req_m.way;
    wr_tag_en = 1'b0;
    wr_tag    = fill_tag;
    wr_val    = 1'b0;
    wr_lck    = 1'b0;
    repl_en   = 1'b0;
    repl_val  = 1'b0;
    if (fill_install) begin
      wr_en     = 1'b1;
      wr_idx    = fill_idx;
      wr_way    = vic.way;
      wr_tag_en = 1'b1;
      wr_val    = 1'b1;
      wr_lck    = fill_lock;
      repl_en   = 1'b1;
      repl_val  = !vic.way;
    end else if (unlock_clear) begin
      wr_en  = 1'b1;
      wr_idx = unlock_idx;
      wr_way = unlock_m.way;
      wr_val = 1'b1;
      wr_lck = 1'b0;
    end else if (inv_kill) begin
      wr_en  = 1'b1;
      wr_idx = req_idx;
      wr_way = req_m.way;
      wr_val = 1'b0;
      wr_lck = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_q   <= RESP_NONE;
      reject_q <= 1'b0;
    end else begin
      resp_q   <= req_acc ? resp_now : RESP_NONE;
      reject_q <= fill_refuse;
    end
  end

  assign done           = (resp_q == RESP_DONE);
  assign xlate_miss_exc = (resp_q == RESP_MISS);
  assign xlate_err_exc  = (resp_q == RESP_ERR);
  assign fill_reject    = reject_q;

endmodule

// File: rtl/icache_inval_unit.sv
module icache_inval_unit
  import icinv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_relocate,
  input  logic              req_xlate_hit,
  input  logic              req_rd_viol,
  input  logic              req_wr_viol,
  input  logic [2:0]        req_attr,
  input  logic              req_user,
  output logic              done,
  output logic              xlate_miss_exc,
  output logic              xlate_err_exc,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_lock,
  output logic              fill_reject,
  input  logic              unlock_valid,
  input  logic [ADDR_W-1:0] unlock_addr,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_locked
);

  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int NRP     = 4;
  localparam int RP_REQ  = 0;
  localparam int RP_FILL = 1;
  localparam int RP_UNLK = 2;
  localparam int RP_LOOK = 3;

  function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  logic [NRP-1:0][IDX_W-1:0]      rd_idx;
  logic [NRP-1:0][TAG_W-1:0]      rd_key;
  logic [NRP-1:0][1:0][TAG_W-1:0] rd_tag;
  logic [NRP-1:0][1:0]            rd_val;
  logic [NRP-1:0][1:0]            rd_lck;
  logic [NRP-1:0]                 rd_repl;
  match_t                         mt [NRP];

  assign rd_idx[RP_REQ]  = addr_index(req_addr);
  assign rd_idx[RP_FILL] = addr_index(fill_addr);
  assign rd_idx[RP_UNLK] = addr_index(unlock_addr);
  assign rd_idx[RP_LOOK] = addr_index(lk_addr);
  assign rd_key[RP_REQ]  = addr_tag(req_addr);
  assign rd_key[RP_FILL] = addr_tag(fill_addr);
  assign rd_key[RP_UNLK] = addr_tag(unlock_addr);
  assign rd_key[RP_LOOK] = addr_tag(lk_addr);

  // Internal events, named for the checker
  logic             req_acc;
  logic             inv_kill;
  logic             fill_install;
  logic             fill_refuse;
  logic             unlock_clear;
  logic             req_hit_locked;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_way;
  logic             wr_tag_en;
  logic [TAG_W-1:0] wr_tag;
  logic             wr_val;
  logic             wr_lck;
  logic             repl_en;
  logic             repl_val;

  icinv_tag_array #(
    .SETS  (SETS),
    .TAG_W (TAG_W),
    .NRP   (NRP)
  ) u_array (
    .clk       (clk),
    .rst       (rst),
    .rd_idx    (rd_idx),
    .rd_tag    (rd_tag),
    .rd_val    (rd_val),
    .rd_lck    (rd_lck),
    .rd_repl   (rd_repl),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_way    (wr_way),
    .wr_tag_en (wr_tag_en),
    .wr_tag    (wr_tag),
    .wr_val    (wr_val),
    .wr_lck    (wr_lck),
    .repl_en   (repl_en),
    .repl_val  (repl_val)
  );

  for (genvar p = 0; p < NRP; p++) begin : g_match
    icinv_way_match #(.TAG_W(TAG_W)) u_match (
      .key  (rd_key[p]),
      .tags (rd_tag[p]),
      .val  (rd_val[p]),
      .lck  (rd_lck[p]),
      .m    (mt[p])
    );
  end

  assign req_hit_locked = mt[RP_REQ].hit && mt[RP_REQ].locked;

  icinv_req_ctrl #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_relocate   (req_relocate),
    .req_xlate_hit  (req_xlate_hit),
    .req_wr_viol    (req_wr_viol),
    .req_idx        (rd_idx[RP_REQ]),
    .req_m          (mt[RP_REQ]),
    .fill_valid     (fill_valid),
    .fill_lock      (fill_lock),
    .fill_idx       (rd_idx[RP_FILL]),
    .fill_tag       (rd_key[RP_FILL]),
    .fill_m         (mt[RP_FILL]),
    .fill_val       (rd_val[RP_FILL]),
    .fill_lck       (rd_lck[RP_FILL]),
    .fill_repl      (rd_repl[RP_FILL]),
    .unlock_valid   (unlock_valid),
    .unlock_idx     (rd_idx[RP_UNLK]),
    .unlock_m       (mt[RP_UNLK]),
    .done           (done),
    .xlate_miss_exc (xlate_miss_exc),
    .xlate_err_exc  (xlate_err_exc),
    .fill_reject    (fill_reject),
    .req_acc        (req_acc),
    .inv_kill       (inv_kill),
    .fill_install   (fill_install),
    .fill_refuse    (fill_refuse),
    .unlock_clear   (unlock_clear),
    .wr_en          (wr_en),
    .wr_idx         (wr_idx),
    .wr_way         (wr_way),
    .wr_tag_en      (wr_tag_en),
    .wr_tag         (wr_tag),
    .wr_val         (wr_val),
    .wr_lck         (wr_lck),
    .repl_en        (repl_en),
    .repl_val       (repl_val)
  );

  assign lk_hit    = mt[RP_LOOK].hit;
  assign lk_locked = mt[RP_LOOK].hit && mt[RP_LOOK].locked;

  // Inputs with no effect on behaviour (R4, R6 load flag) and unused read bits
  logic unused_bits;
  assign unused_bits = ^{req_addr[OFF_W-1:0], fill_addr[OFF_W-1:0],
                         unlock_addr[OFF_W-1:0], lk_addr[OFF_W-1:0],
                         req_attr, req_user, req_rd_viol,
                         rd_repl[RP_REQ], rd_repl[RP_UNLK], rd_repl[RP_LOOK],
                         mt[RP_LOOK].way, mt[RP_FILL].locked, mt[RP_UNLK].locked,
                         fill_install, unlock_clear, req_hit_locked, req_acc};

endmodule

// File: rtl/icinv_checker.sv
module icinv_checker (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic req_relocate,
  input logic req_xlate_hit,
  input logic req_wr_viol,
  input logic fill_valid,
  input logic unlock_valid,
  input logic done,
  input logic xlate_miss_exc,
  input logic xlate_err_exc,
  input logic fill_reject,
  input logic fill_refuse,
  input logic inv_kill
);

  logic acc;
  assign acc = req_valid && req_ready;

  // R3: responses never overlap
  a_r3_resp_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, xlate_miss_exc, xlate_err_exc}));

  // R3: an accepted request is answered in the next cycle
  a_r3_resp_follows_accept: assert property (@(posedge clk) disable iff (rst)
    acc |=> (done || xlate_miss_exc || xlate_err_exc));

  // R3: no answer without acceptance
  a_r3_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !(done || xlate_miss_exc || xlate_err_exc));

  // R1: an invalidation always completes normally
  a_r1_kill_done: assert property (@(posedge clk) disable iff (rst)
    inv_kill |=> done);

  // R5: missing translation under relocation
  a_r5_miss_raised: assert property (@(posedge clk) disable iff (rst)
    (acc && req_relocate && !req_xlate_hit) |=> xlate_miss_exc);

  // R6: store permission violation
  a_r6_err_raised: assert property (@(posedge clk) disable iff (rst)
    (acc && !(req_relocate && !req_xlate_hit) && req_wr_viol) |=> xlate_err_exc);

  // R7: requests held off while fill or unlock are active
  a_r7_ready_blocked: assert property (@(posedge clk) disable iff (rst)
    (fill_valid || unlock_valid) |-> !req_ready);

  // R10: refused fill flagged in the next cycle
  a_r10_reject_follows: assert property (@(posedge clk) disable iff (rst)
    fill_refuse |=> fill_reject);

  // R10: the flag lasts only one cycle unless refused again
  a_r10_reject_single: assert property (@(posedge clk) disable iff (rst)
    (fill_reject && !fill_refuse) |=> !fill_reject);

endmodule

bind icache_inval_unit icinv_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_relocate   (req_relocate),
  .req_xlate_hit  (req_xlate_hit),
  .req_wr_viol    (req_wr_viol),
  .fill_valid     (fill_valid),
  .unlock_valid   (unlock_valid),
  .done           (done),
  .xlate_miss_exc (xlate_miss_exc),
  .xlate_err_exc  (xlate_err_exc),
  .fill_reject    (fill_reject),
  .fill_refuse    (fill_refuse),
  .inv_kill       (inv_kill)
);

// File: tb/icache_inval_unit_bench.sv
module icache_inval_unit_bench;

  localparam logic [1:0] OP_FILL = 2'd0;
  localparam logic [1:0] OP_UNLK = 2'd1;
  localparam logic [1:0] OP_REQ  = 2'd2;
  // expected response codes
  localparam logic [1:0] E_NONE = 2'd0;
  localparam logic [1:0] E_DONE = 2'd1;
  localparam logic [1:0] E_MISS = 2'd2;
  localparam logic [1:0] E_ERR  = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic        lock;
    logic        reloc;
    logic        xhit;
    logic        rdv;
    logic        wrv;
    logic [2:0]  attr;
    logic        user;
    logic [1:0]  resp;
    logic        rej;
    logic        hit;
    logic        lck;
    logic [3:0]  rq;
  } vec_t;

  // tag [31:10], set [9:4], offset [3:0]
  function automatic logic [31:0] mk(input int t, input int s);
    logic [31:0] a;
    a = {t[21:0], s[5:0], 4'h0};
    return a;
  endfunction

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{OP_FILL, mk(1,5), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, E_NONE, 1'b0, 1'b1, 1'b0, 4'd8},  // R8
    '{OP_REQ,  mk(1,5), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, E_DONE, 1'b0, 1'b0, 1'b0, 4'd1},  // R1
    '{OP_REQ,  mk(1,5), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, E_DONE, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 miss
    '{OP_FILL, mk(2,5), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, E_NONE, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 locked
    '{OP_REQ,  mk(2,5), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, E_DONE, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 locked
    '{OP_REQ,  mk(2,5), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, E_MISS, 1'b0, 1'b1, 1'b1, 4'd5},  // R5
    '{OP_FILL, mk(3,9), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, E_NONE, 1'b0, 1'b1, 1'b0, 4'd8},  // R8
    '{OP_REQ,  mk(3,9), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, E_MISS, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 untouched
    '{OP_REQ,  mk(3,9), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, E_DONE, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 relocation off
    '{OP_FILL, mk(3,9), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, E_NONE, 1'b0, 1'b1, 1'b0, 4'd8},  // R8
    '{OP_REQ,  mk(3,9), 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0, E_ERR,  1'b0, 1'b1, 1'b0, 4'd6},  // R6 store fault
    '{OP_REQ,  mk(3,9), 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, E_DONE, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 load flag only
    '{OP_FILL, mk(3,9), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, E_NONE, 1'b0, 1'b1, 1'b0, 4'd8},  // R8
    '{OP_REQ,  mk(3,9), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd7, 1'b1, E_DONE, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
    '{OP_FILL, mk(4,9), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, E_NONE, 1'b0, 1'b1, 1'b0, 4'd8},  // R8
    '{OP_REQ,  mk(4,9), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd5, 1'b0, E_DONE, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
    '{OP_UNLK, mk(2,5), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, E_NONE, 1'b0, 1'b1, 1'b0, 4'd11}, // R11
    '{OP_REQ,  mk(2,5), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, E_DONE, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 after unlock
    '{OP_UNLK, mk(2,5), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, E_NONE, 1'b0, 1'b0, 1'b0, 4'd11}  // R11 miss
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_relocate = 1'b0;
  logic        req_xlate_hit = 1'b0;
  logic        req_rd_viol = 1'b0;
  logic        req_wr_viol = 1'b0;
  logic [2:0]  req_attr = '0;
  logic        req_user = 1'b0;
  logic        done;
  logic        xlate_miss_exc;
  logic        xlate_err_exc;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_addr = '0;
  logic        fill_lock = 1'b0;
  logic        fill_reject;
  logic        unlock_valid = 1'b0;
  logic [31:0] unlock_addr = '0;
  logic [31:0] lk_addr = '0;
  logic        lk_hit;
  logic        lk_locked;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #10 clk = !clk;

  icache_inval_unit u_icache_inval_unit (.*);

  function automatic logic [1:0] resp_code();
    if (done)           return E_DONE;
    if (xlate_miss_exc) return E_MISS;
    if (xlate_err_exc)  return E_ERR;
    return E_NONE;
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic look(input logic [31:0] a, input logic eh, input logic el, input string rq);
    lk_addr = a;
    #1;
    chk(rq, "lookup hit", 32'(lk_hit), 32'(eh));
    chk(rq, "lookup locked", 32'(lk_locked), 32'(el));
  endtask

  task automatic do_fill(input logic [31:0] a, input logic l);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = a; fill_lock = l;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic apply(input vec_t v, input int k);
    string rq;
    rq = $sformatf("R%0d(vec %0d)", v.rq, k);
    @(negedge clk);
    lk_addr = v.addr;
    case (v.op)
      OP_FILL: begin fill_valid = 1'b1; fill_addr = v.addr; fill_lock = v.lock; end
      OP_UNLK: begin unlock_valid = 1'b1; unlock_addr = v.addr; end
      default: begin
        req_valid = 1'b1; req_addr = v.addr; req_relocate = v.reloc;
        req_xlate_hit = v.xhit; req_rd_viol = v.rdv; req_wr_viol = v.wrv;
        req_attr = v.attr; req_user = v.user;
      end
    endcase
    @(negedge clk);
    fill_valid = 1'b0; unlock_valid = 1'b0; req_valid = 1'b0;
    chk(rq, "response", 32'(resp_code()), 32'(v.resp));
    chk(rq, "fill_reject", 32'(fill_reject), 32'(v.rej));
    chk(rq, "lookup hit", 32'(lk_hit), 32'(v.hit));
    chk(rq, "lookup locked", 32'(lk_locked), 32'(v.lck));
    @(negedge clk);
    // R3: pulse lasts one cycle
    chk("R3", "response cleared", 32'(resp_code()), 32'(E_NONE));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12", "done", 32'(done), 0);
    chk("R12", "miss", 32'(xlate_miss_exc), 0);
    chk("R12", "err", 32'(xlate_err_exc), 0);
    chk("R7", "ready idle", 32'(req_ready), 1);
    look(mk(1,5), 1'b0, 1'b0, "R12");

    for (int k = 0; k < NV; k++) apply(VECS[k], k);

    // R7: fill blocks a request for that cycle
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = mk(7,12); fill_lock = 1'b0;
    req_valid = 1'b1; req_addr = mk(7,12); req_relocate = 1'b0; req_xlate_hit = 1'b1;
    req_wr_viol = 1'b0; req_rd_viol = 1'b0;
    #1;
    chk("R7", "ready during fill", 32'(req_ready), 0);
    @(negedge clk);
    fill_valid = 1'b0;
    chk("R7", "no response when blocked", 32'(resp_code()), 32'(E_NONE));
    unlock_valid = 1'b1; unlock_addr = mk(8,12);
    #1;
    chk("R7", "ready during unlock", 32'(req_ready), 0);
    @(negedge clk);
    unlock_valid = 1'b0;
    chk("R7", "no response when blocked", 32'(resp_code()), 32'(E_NONE));
    #1;
    chk("R7", "ready idle again", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", "request accepted once free", 32'(resp_code()), 32'(E_DONE));
    look(mk(7,12), 1'b0, 1'b0, "R1");

    // R9: round-robin among unlocked ways, set 20
    do_fill(mk(11,20), 1'b0);
    do_fill(mk(12,20), 1'b0);
    do_fill(mk(13,20), 1'b0);   // replaces way 0 (tag 11)
    look(mk(11,20), 1'b0, 1'b0, "R9");
    look(mk(12,20), 1'b1, 1'b0, "R9");
    look(mk(13,20), 1'b1, 1'b0, "R9");
    do_fill(mk(14,20), 1'b0);   // replaces way 1 (tag 12)
    look(mk(12,20), 1'b0, 1'b0, "R9");
    look(mk(13,20), 1'b1, 1'b0, "R9");
    look(mk(14,20), 1'b1, 1'b0, "R9");

    // R9: locked way is spared, set 21
    do_fill(mk(21,21), 1'b1);
    do_fill(mk(22,21), 1'b0);
    do_fill(mk(23,21), 1'b0);   // only way 1 unlocked
    look(mk(21,21), 1'b1, 1'b1, "R9");
    look(mk(22,21), 1'b0, 1'b0, "R9");
    do_fill(mk(24,21), 1'b1);   // replaces tag 23, now both locked
    look(mk(23,21), 1'b0, 1'b0, "R9");
    look(mk(24,21), 1'b1, 1'b1, "R8");

    // R10: refused fill
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = mk(25,21); fill_lock = 1'b0;
    @(negedge clk);
    fill_valid = 1'b0;
    chk("R10", "fill_reject", 32'(fill_reject), 1);
    look(mk(25,21), 1'b0, 1'b0, "R10");
    look(mk(21,21), 1'b1, 1'b1, "R10");
    look(mk(24,21), 1'b1, 1'b1, "R10");
    @(negedge clk);
    chk("R10", "fill_reject one cycle", 32'(fill_reject), 0);

    // R8: refill of present line rewrites its lock
    do_fill(mk(24,21), 1'b0);
    look(mk(24,21), 1'b1, 1'b0, "R8");

    // R12: reset clears array
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    look(mk(21,21), 1'b0, 1'b0, "R12");
    look(mk(13,20), 1'b0, 1'b0, "R12");
    // R12: replacement bit back to 0 -> after two fills, third hits way 0
    do_fill(mk(31,20), 1'b0);
    do_fill(mk(32,20), 1'b0);
    do_fill(mk(33,20), 1'b0);
    look(mk(31,20), 1'b0, 1'b0, "R12");
    look(mk(32,20), 1'b1, 1'b0, "R12");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule